// File: doc/BRIEF.md
# Power Factor Correction Fault and Start-up Supervisor

This block supervises a boost power factor correction stage from a set of already digitized comparator flags. It watches the supply for the turn-on and under-voltage levels, the bulk voltage feedback for the open-loop level and two over-voltage levels, a separate over-voltage sense input with its own rise and release levels, and a flag that says the bulk voltage has reached 95% of its rated value. From these it decides whether the power switch may be driven, whether the soft-start ramp is in charge, and whether the stage is parked in standby.

Each fault condition has to persist for its own blanking time, counted in clock cycles, before it takes effect. Each fault then holds until its own release condition is met, so every fault has its own hysteresis. Faults that call for a restart send the start-up sequencer back to its idle state, so switching resumes through soft-start. The primary over-voltage path only pauses the gate and resumes in normal regulation. All four fault conditions are reported at the same time as separate bits.

Top module: `pfc_fault_mgr`

## Requirements
- R1: After reset, `fault_o` is 4'b0001 (bit 0 under-voltage, bit 1 open loop, bit 2 primary over-voltage, bit 3 secondary over-voltage). `gate_en_o`, `softstart_o` and `standby_o` are all low.
- R2: The under-voltage bit clears at the first clock edge that samples `vcc_on_i` and `vs_olp_i` both high. Once it is clear, a low `vcc_on_i` alone has no effect. Only a sampled low `vcc_ok_i` sets it again.
- R3: `gate_en_o` goes low in the same cycle that `vcc_ok_i` is low, with no clock edge needed. The under-voltage bit is set at the next edge.
- R4: The open-loop bit (bit 1) and `standby_o` set only after `vs_olp_i` is sampled low on OLP_BLANK consecutive edges. A shorter low run resets the count and has no effect.
- R5: The open-loop bit clears at the first edge that samples `vs_olp_i` high. Switching then resumes with `softstart_o` high.
- R6: Bit 2 sets after `vs_ov_hi_i` is sampled high on OVP1_BLANK consecutive edges, and the gate turns off. The bit holds while `vs_ov_lo_i` is high and clears at the edge that samples it low. Switching then resumes in the state held before, with no new soft-start.
- R7: Bit 3 sets after `ovp_hi_i` is sampled high on OVP2_BLANK consecutive edges. It clears at the edge that samples `ovp_lo_i` low, and switching restarts through soft-start.
- R8: While bits 2 and 3 are both set, the gate stays off until both have been released.
- R9: `softstart_o` is high from the cycle after the last restart-type fault clears until the edge that samples `bulk95_i` high. From then on the block is in normal regulation with `softstart_o` low.
- R10: `gate_en_o` is high only when `vcc_ok_i` is high, all four fault bits are clear, and the sequencer is not idle. Several fault bits can be set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply above the turn-on level |
| vcc_ok_i | input | 1 | Supply above the under-voltage level |
| vs_olp_i | input | 1 | Bulk feedback above the open-loop level |
| vs_ov_hi_i | input | 1 | Bulk feedback above the primary over-voltage trip level |
| vs_ov_lo_i | input | 1 | Bulk feedback above the primary over-voltage release level |
| ovp_hi_i | input | 1 | Secondary sense above its trip level |
| ovp_lo_i | input | 1 | Secondary sense above its release level |
| bulk95_i | input | 1 | Bulk voltage at or above 95% of rated |
| gate_en_o | output | 1 | Permission to drive the power switch |
| softstart_o | output | 1 | Soft-start ramp in control |
| standby_o | output | 1 | Open-loop standby active |
| fault_o | output | 4 | Fault bits: 0 under-voltage, 1 open loop, 2 primary over-voltage, 3 secondary over-voltage |

## Verification
Each fault flag is driven with a run one edge shorter than its blanking time and then with a full run. This separates a counter that qualifies too early from one that restarts correctly. Each over-voltage flag is held in the band between its trip and release levels, which shows whether the release uses the low comparator or the trip comparator. The sequencer state is then observed after each release, so that an over-voltage recovery that restarts soft-start wrongly, or one that fails to restart it, shows up directly. A case where both over-voltage paths overlap and release one after the other tells a gate that waits for both releases from one that waits for only one. Every cycle is compared against a behavioural model.

// File: rtl/pfc_prot_pkg.sv
package pfc_prot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOFT = 2'd1,
    ST_RUN  = 2'd2
  } pfc_state_e;

  localparam int FLT_W    = 4;
  localparam int FLT_UVLO = 0;
  localparam int FLT_OLP  = 1;
  localparam int FLT_OVP1 = 2;
  localparam int FLT_OVP2 = 3;

  // faults that demand a full restart through soft-start
  function automatic logic needs_restart(input logic [FLT_W-1:0] f);
    return f[FLT_UVLO] | f[FLT_OLP] | f[FLT_OVP2];
  endfunction

  // any fault at all blocks the gate
  function automatic logic any_fault(input logic [FLT_W-1:0] f);
    return |f;
  endfunction

endpackage

// File: rtl/pfc_blank_qual.sv
module pfc_blank_qual #(
  parameter int BLANK = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic qual_o
);
  localparam int CW = $clog2(BLANK + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK - 1);
  localparam logic [CW-1:0] FULL = CW'(BLANK);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!flag_i)        cnt_q <= '0;
    else if (cnt_q != FULL)  cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = flag_i && (cnt_q >= LAST);

  // R4
  blank_prior_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (BLANK >= 2 && qual_o) |-> $past(flag_i));

endmodule

// File: rtl/pfc_fault_latch.sv
module pfc_fault_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R10
  latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(set_i));

  // R10
  latch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_o) |-> ($past(clr_i) && !$past(set_i)));

endmodule

// File: rtl/pfc_restart_seq.sv
module pfc_restart_seq
  import pfc_prot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLT_W-1:0] fault_i,
  input  logic             bulk95_i,
  output pfc_state_e       state_o
);
  pfc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (needs_restart(fault_i)) state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: state_d = ST_SOFT;
        ST_SOFT: if (bulk95_i) state_d = ST_RUN;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R9
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && !$past(state_q == ST_RUN)) |-> $past(bulk95_i));

  // R9
  soft_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SOFT) && !$past(state_q == ST_SOFT)) |-> $past(state_q == ST_IDLE));

endmodule

// File: rtl/pfc_fault_mgr.sv
module pfc_fault_mgr
  import pfc_prot_pkg::*;
#(
  parameter int OLP_BLANK  = 50,
  parameter int OVP1_BLANK = 600,
  parameter int OVP2_BLANK = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_ok_i,
  input  logic       vs_olp_i,
  input  logic       vs_ov_hi_i,
  input  logic       vs_ov_lo_i,
  input  logic       ovp_hi_i,
  input  logic       ovp_lo_i,
  input  logic       bulk95_i,
  output logic       gate_en_o,
  output logic       softstart_o,
  output logic       standby_o,
  output logic [3:0] fault_o
);
  logic [FLT_W-1:0] flt;
  logic             olp_qual, ovp1_qual, ovp2_qual;
  logic             uvlo_set, uvlo_clr;
  pfc_state_e       state;

  assign uvlo_set = !vcc_ok_i;
  assign uvlo_clr = vcc_on_i && vs_olp_i;

  pfc_fault_latch #(.RST_VAL(1'b1)) i_uvlo (
    .clk(clk), .rst_n(rst_n), .set_i(uvlo_set), .clr_i(uvlo_clr), .q_o(flt[FLT_UVLO]));

  pfc_blank_qual #(.BLANK(OLP_BLANK)) i_olp_blank (
    .clk(clk), .rst_n(rst_n), .flag_i(!vs_olp_i), .qual_o(olp_qual));
  pfc_fault_latch #(.RST_VAL(1'b0)) i_olp (
    .clk(clk), .rst_n(rst_n), .set_i(olp_qual), .clr_i(vs_olp_i), .q_o(flt[FLT_OLP]));

  pfc_blank_qual #(.BLANK(OVP1_BLANK)) i_ovp1_blank (
    .clk(clk), .rst_n(rst_n), .flag_i(vs_ov_hi_i), .qual_o(ovp1_qual));
  pfc_fault_latch #(.RST_VAL(1'b0)) i_ovp1 (
    .clk(clk), .rst_n(rst_n), .set_i(ovp1_qual), .clr_i(!vs_ov_lo_i), .q_o(flt[FLT_OVP1]));

  pfc_blank_qual #(.BLANK(OVP2_BLANK)) i_ovp2_blank (
    .clk(clk), .rst_n(rst_n), .flag_i(ovp_hi_i), .qual_o(ovp2_qual));
  pfc_fault_latch #(.RST_VAL(1'b0)) i_ovp2 (
    .clk(clk), .rst_n(rst_n), .set_i(ovp2_qual), .clr_i(!ovp_lo_i), .q_o(flt[FLT_OVP2]));

  pfc_restart_seq i_seq (
    .clk(clk), .rst_n(rst_n), .fault_i(flt), .bulk95_i(bulk95_i), .state_o(state));

  assign gate_en_o   = vcc_ok_i && !any_fault(flt) && (state != ST_IDLE);
  assign softstart_o = (state == ST_SOFT);
  assign standby_o   = flt[FLT_OLP];
  assign fault_o     = flt;

  // R3
  uvlo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok_i |=> fault_o[FLT_UVLO]);

  // R2
  uvlo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o[FLT_UVLO]) |-> $past(vcc_on_i && vs_olp_i));

  // R5
  olp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o[FLT_OLP]) |-> $past(vs_olp_i));

  // R6
  ovp1_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o[FLT_OVP1]) |-> !$past(vs_ov_lo_i));

  // R7
  ovp2_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o[FLT_OVP2]) |-> !$past(ovp_lo_i));

  // R8
  both_ovp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o[FLT_OVP1] || fault_o[FLT_OVP2]) |-> !gate_en_o);

endmodule

// File: tb/test_pfc_fault_mgr.sv
module test_pfc_fault_mgr;
  localparam int OLP_B  = 50;
  localparam int OVP1_B = 600;
  localparam int OVP2_B = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on = 0, vcc_ok = 0, vs_olp = 0, vs_hi = 0, vs_lo = 0;
  logic ovp_hi = 0, ovp_lo = 0, bulk95 = 0;
  logic gate_en, softstart, standby;
  logic [3:0] fault;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  always #10 clk = ~clk;

  pfc_fault_mgr #(.OLP_BLANK(OLP_B), .OVP1_BLANK(OVP1_B), .OVP2_BLANK(OVP2_B)) i_pfc_fault_mgr (
    .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_ok_i(vcc_ok), .vs_olp_i(vs_olp),
    .vs_ov_hi_i(vs_hi), .vs_ov_lo_i(vs_lo), .ovp_hi_i(ovp_hi), .ovp_lo_i(ovp_lo),
    .bulk95_i(bulk95), .gate_en_o(gate_en), .softstart_o(softstart), .standby_o(standby),
    .fault_o(fault));

  // behavioural reference: 0 idle, 1 soft-start, 2 regulating
  bit m_uv = 1, m_olp = 0, m_ov1 = 0, m_ov2 = 0;
  int m_st = 0, c_olp = 0, c_ov1 = 0, c_ov2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_uv = 1; m_olp = 0; m_ov1 = 0; m_ov2 = 0; m_st = 0;
      c_olp = 0; c_ov1 = 0; c_ov2 = 0;
    end else begin
      bit restart;
      restart = m_uv || m_olp || m_ov2;
      if (restart) m_st = 0;
      else if (m_st == 0) m_st = 1;
      else if (m_st == 1 && bulk95) m_st = 2;
      if (!vcc_ok) m_uv = 1;
      else if (m_uv && vcc_on && vs_olp) m_uv = 0;
      if (!vs_olp) begin
        c_olp++;
        if (c_olp >= OLP_B) m_olp = 1;
      end else begin
        c_olp = 0; m_olp = 0;
      end
      if (vs_hi) begin
        c_ov1++;
        if (c_ov1 >= OVP1_B) m_ov1 = 1;
        else if (!vs_lo) m_ov1 = 0;
      end else begin
        c_ov1 = 0;
        if (!vs_lo) m_ov1 = 0;
      end
      if (ovp_hi) begin
        c_ov2++;
        if (c_ov2 >= OVP2_B) m_ov2 = 1;
        else if (!ovp_lo) m_ov2 = 0;
      end else begin
        c_ov2 = 0;
        if (!ovp_lo) m_ov2 = 0;
      end
    end
  end

  function automatic logic [3:0] exp_fault();
    return {m_ov2, m_ov1, m_olp, m_uv};
  endfunction

  function automatic logic exp_gate();
    return vcc_ok && (m_st != 0) && (exp_fault() == 4'b0);
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if (gate_en !== exp_gate() || softstart !== (m_st == 1) ||
          standby !== m_olp || fault !== exp_fault()) begin
        n_fail++;
        $display("FAIL %s t=%0t act gate=%b ss=%b sb=%b flt=%b exp gate=%b ss=%b sb=%b flt=%b",
                 cur_req, $time, gate_en, softstart, standby, fault,
                 exp_gate(), (m_st == 1), m_olp, exp_fault());
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s point check act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic run_tests();
    // R1 reset state
    step(3);
    chk("R1", fault, 4'b0001);
    chk("R1", {1'b0, gate_en, softstart, standby}, 4'b0000);
    rst_n = 1'b1;
    step(1);
    cmp_on = 1;
    // R2 start needs both flags
    cur_req = "R2";
    vcc_ok = 1; vcc_on = 1; step(3);
    chk("R2", fault[0], 1'b1);
    vs_olp = 1; vs_lo = 0; ovp_lo = 0; step(1);
    chk("R2", fault[0], 1'b0);
    // R9 soft-start until bulk at 95%
    cur_req = "R9";
    step(5);
    chk("R9", {2'b0, softstart, gate_en}, 4'b0011);
    bulk95 = 1; step(2);
    chk("R9", {2'b0, softstart, gate_en}, 4'b0001);
    // R2 hysteresis: losing turn-on flag alone is ignored
    cur_req = "R2";
    vcc_on = 0; step(10);
    chk("R2", {fault[0], gate_en, 2'b0}, 4'b0100);
    // R3 under-voltage
    cur_req = "R3";
    vcc_ok = 0; #3;
    chk("R3", {3'b0, gate_en}, 4'b0000);
    step(1);
    chk("R3", fault[0], 1'b1);
    vcc_ok = 1; vcc_on = 1; bulk95 = 0; step(4);
    bulk95 = 1; step(3);
    // R4 open-loop blanking
    cur_req = "R4";
    vs_olp = 0; step(OLP_B - 1);
    vs_olp = 1; step(1);
    chk("R4", {standby, fault[1], 2'b0}, 4'b0000);
    vs_olp = 0; step(OLP_B + 5);
    chk("R4", {standby, fault[1], 2'b0}, 4'b1100);
    // R5 recovery through soft-start
    cur_req = "R5";
    bulk95 = 0; vs_olp = 1; step(3);
    chk("R5", {fault[1], softstart, 2'b0}, 4'b0100);
    bulk95 = 1; step(3);
    // R6 primary over-voltage
    cur_req = "R6";
    vs_lo = 1; vs_hi = 1; step(OVP1_B - 1);
    vs_hi = 0; step(1);
    chk("R6", fault[2], 1'b0);
    vs_hi = 1; step(OVP1_B + 2);
    chk("R6", {fault[2], gate_en, 2'b0}, 4'b1000);
    vs_hi = 0; step(20);
    chk("R6", fault[2], 1'b1);
    vs_lo = 0; step(2);
    chk("R6", {fault[2], gate_en, softstart, 1'b0}, 4'b0100);
    // R7 secondary over-voltage
    cur_req = "R7";
    ovp_lo = 1; ovp_hi = 1; step(OVP2_B + 2);
    chk("R7", {fault[3], gate_en, 2'b0}, 4'b1000);
    ovp_hi = 0; step(20);
    chk("R7", fault[3], 1'b1);
    bulk95 = 0; ovp_lo = 0; step(3);
    chk("R7", {fault[3], softstart, gate_en, 1'b0}, 4'b0110);
    bulk95 = 1; step(3);
    // R8 both paths overlapping
    cur_req = "R8";
    vs_lo = 1; ovp_lo = 1; vs_hi = 1; ovp_hi = 1; step(OVP1_B + 3);
    chk("R8", fault, 4'b1100);
    vs_hi = 0; ovp_hi = 0; ovp_lo = 0; step(10);
    chk("R8", {fault[3:2], gate_en, 1'b0}, 4'b0100);
    vs_lo = 0; step(3);
    chk("R8", {fault[3:2], gate_en, 1'b0}, 4'b0010);
    // R10 several faults at once
    cur_req = "R10";
    vs_olp = 0; vs_lo = 1; vs_hi = 1; step(OVP1_B + 2);
    chk("R10", fault, 4'b0110);
    vs_olp = 1; vs_hi = 0; vs_lo = 0; step(5);
    chk("R10", fault, 4'b0000);
    step(5);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired in %s", cur_req);
      end
    join_any
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule